// File: doc/BRIEF.md
# Shared Bus Arbiter with Split Masking

This arbiter decides which of `N_MST` masters owns a shared address/data bus. It is built either with a fixed-priority policy, where the highest-numbered eligible requester wins, or with a round-robin policy. In round-robin mode the search starts one index above the current owner and wraps around. When no eligible master requests the bus, ownership parks on a master chosen by parameter.

The arbiter takes a new decision only on a cycle in which `ready` is high, which marks the end of the current transfer. On any other cycle the grant holds.

When split support is built in, a transfer that ends with `split_resp` high removes the current owner from arbitration. That master stays out until the slave raises its bit on `split_release`. With split support left out, the masking logic is not generated and both split inputs are ignored.

Top module: `bus_arbiter`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `owner` equals `PARK_MST` and `grant` has only bit `PARK_MST` set.
- R2: After reset, `grant` always has exactly one bit set, and that bit is bit number `owner`.
- R3: On a cycle with `ready` low, `grant` and `owner` do not change at the next clock edge.
- R4: With `ROUND_ROBIN`=0, a `ready` cycle gives the bus to the eligible requester with the highest index.
- R5: With `ROUND_ROBIN`=1, a `ready` cycle gives the bus to the first eligible requester found at indices owner+1, owner+2, and so on, modulo `N_MST`.
- R6: A `ready` cycle with no request at all gives the bus to `PARK_MST`.
- R7: With `SPLIT_EN`=1, a `ready` cycle with `split_resp` high marks the current owner as held. A held master is not eligible, including in the decision made on that same edge. It stays held until a cycle in which its bit of `split_release` is high. A release takes effect on any cycle, whether or not `ready` is high, and the released master is eligible again on that same cycle.
- R8: If `split_release` names the current owner on the same `ready` cycle in which `split_resp` holds that owner, the hold wins and the master stays held.
- R9: With `SPLIT_EN`=0, `split_resp` and `split_release` have no effect on `grant` or `owner`.
- R10: A `ready` cycle in which masters request but every requester is held gives the bus to `PARK_MST`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req | input | N_MST | One request line per master |
| ready | input | 1 | High on the last cycle of the current transfer |
| split_resp | input | 1 | Qualified by `ready`: the transfer ended with a split |
| split_release | input | N_MST | The slave frees the held masters named here |
| grant | output | N_MST | One-hot bus grant |
| owner | output | $clog2(N_MST) | Index of the granted master |

## Verification
Three instances receive the same long pseudo-random stream of request patterns, `ready` gaps, split responses and release bits. The instances are a round-robin arbiter with split support, a fixed-priority arbiter with split support, and a round-robin arbiter without it. The stalls on `ready` separate holding behaviour from decisions. Patterns with several requesters separate highest-index wins from rotation after the owner. Idle cycles and cycles in which every requester is held both test the fallback to the park master. The split-free instance sees the same split traffic, so any leak of that traffic into its choices shows up as a mismatch against the requirement-level model.

// File: rtl/bus_arbiter.sv
module bus_arbiter #(
  parameter int N_MST       = 4,
  parameter bit ROUND_ROBIN = 1'b1,
  parameter int PARK_MST    = 0,
  parameter bit SPLIT_EN    = 1'b1
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic [N_MST-1:0]                       req,
  input  logic                                   ready,
  input  logic                                   split_resp,
  input  logic [N_MST-1:0]                       split_release,
  output logic [N_MST-1:0]                       grant,
  output logic [(N_MST > 1 ? $clog2(N_MST) : 1)-1:0] owner
);
  localparam int IW = (N_MST > 1) ? $clog2(N_MST) : 1;
  localparam logic [IW-1:0] PARK_IDX = IW'(PARK_MST);

  logic [N_MST-1:0] held_nxt;
  logic [N_MST-1:0] elig;
  logic [IW-1:0]    pick;
  logic             found;

  generate
    if (SPLIT_EN) begin : g_split
      logic [N_MST-1:0] held;
      logic [N_MST-1:0] set_bit;

      assign set_bit  = (ready && split_resp) ? (N_MST'(1) << owner) : '0;
      assign held_nxt = (held & ~split_release) | set_bit;

      always_ff @(posedge clk) begin
        if (!rst_n) held <= '0;
        else        held <= held_nxt;
      end

      // R7
      split_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ready && split_resp) && $past(owner) != PARK_IDX) |-> owner != $past(owner));
    end else begin : g_nosplit
      logic unused_split;
      assign unused_split = split_resp ^ (^split_release);
      assign held_nxt = '0;
    end
  endgenerate

  assign elig = req & ~held_nxt;

  always_comb begin
    pick  = PARK_IDX;
    found = 1'b0;
    if (ROUND_ROBIN) begin
      for (int k = 1; k <= N_MST; k++) begin
        if (!found && elig[(int'(owner) + k) % N_MST]) begin
          pick  = IW'((int'(owner) + k) % N_MST);
          found = 1'b1;
        end
      end
    end else begin
      for (int i = 0; i < N_MST; i++) begin
        if (elig[i]) pick = IW'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      owner <= PARK_IDX;
      grant <= N_MST'(1) << PARK_IDX;
    end else if (ready) begin
      owner <= pick;
      grant <= N_MST'(1) << pick;
    end
  end

  // R2
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant) && grant[owner]);

  // R3
  hold_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(ready) |-> ($stable(grant) && $stable(owner)));

  // R6
  idle_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ready) && $past(req) == '0) |-> owner == PARK_IDX);
endmodule

// File: tb/sim_bus_arbiter.sv
module sim_bus_arbiter;
  localparam int CLK_PERIOD = 10;
  localparam int NCYC = 6000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] req = '0;
  logic ready = 1'b0;
  logic split_resp = 1'b0;
  logic [3:0] split_release = '0;
  logic [3:0] g0, g1, g2;
  logic [1:0] o0, o1, o2;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_arbiter #(.N_MST(4), .ROUND_ROBIN(1'b1), .PARK_MST(2), .SPLIT_EN(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .req(req), .ready(ready), .split_resp(split_resp),
    .split_release(split_release), .grant(g0), .owner(o0));
  bus_arbiter #(.N_MST(4), .ROUND_ROBIN(1'b0), .PARK_MST(0), .SPLIT_EN(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .req(req), .ready(ready), .split_resp(split_resp),
    .split_release(split_release), .grant(g1), .owner(o1));
  bus_arbiter #(.N_MST(4), .ROUND_ROBIN(1'b1), .PARK_MST(3), .SPLIT_EN(1'b0)) u2 (
    .clk(clk), .rst_n(rst_n), .req(req), .ready(ready), .split_resp(split_resp),
    .split_release(split_release), .grant(g2), .owner(o2));

  int exp_own [3];
  logic [3:0] exp_held [3];
  string tag [3];
  int cfg_rr [3] = '{1, 0, 1};
  int cfg_sp [3] = '{1, 1, 0};
  int cfg_pk [3] = '{2, 0, 3};

  task automatic check(input int i, input logic [1:0] o, input logic [3:0] g);
    vectors++;
    if (o !== 2'(exp_own[i]) || g !== 4'(1 << exp_own[i])) begin
      miscompares++;
      $display("FAIL %s inst u%0d: owner=%0d grant=%b expected owner=%0d grant=%b",
               tag[i], i, o, g, exp_own[i], 4'(1 << exp_own[i]));
    end
    vectors++;
    if ($countones(g) != 1 || g[o] !== 1'b1) begin
      miscompares++;
      $display("FAIL R2 inst u%0d: grant=%b owner=%0d expected one-hot at owner", i, g, o);
    end
  endtask

  task automatic model(input int i);
    logic [3:0] hn, el;
    int nx;
    hn = '0;
    if (cfg_sp[i] != 0) begin
      hn = exp_held[i] & ~split_release;
      if (ready && split_resp) hn = hn | 4'(1 << exp_own[i]);
    end
    el = req & ~hn;
    nx = exp_own[i];
    if (!ready) tag[i] = "R3";
    else if (req == 0) tag[i] = "R6";
    else if (el == 0) tag[i] = "R10";
    else if (cfg_sp[i] != 0 && split_resp && split_release[exp_own[i]]) tag[i] = "R8";
    else if (cfg_sp[i] != 0 && (split_resp || exp_held[i] != 0)) tag[i] = "R7";
    else if (cfg_sp[i] == 0 && (split_resp || split_release != 0)) tag[i] = "R9";
    else tag[i] = (cfg_rr[i] != 0) ? "R5" : "R4";
    if (ready) begin
      if (el == 0) nx = cfg_pk[i];
      else if (cfg_rr[i] == 0) begin
        for (int b = 0; b < 4; b++) if (el[b]) nx = b;
      end else begin
        for (int k = 4; k >= 1; k--) if (el[(exp_own[i] + k) % 4]) nx = (exp_own[i] + k) % 4;
      end
    end
    exp_own[i] = nx;
    exp_held[i] = hn;
  endtask

  initial begin
    logic [31:0] rng;
    rng = 32'h1234_5678;
    for (int i = 0; i < 3; i++) begin
      exp_own[i] = cfg_pk[i];
      exp_held[i] = '0;
      tag[i] = "R1";
    end
    req = 4'hF;
    ready = 1'b1;
    split_resp = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state, with traffic on every input
    check(0, o0, g0); check(1, o1, g1); check(2, o2, g2);
    rst_n = 1'b1;
    req = '0;
    ready = 1'b0;
    split_resp = 1'b0;
    @(negedge clk);
    // R1: first cycle after reset release
    check(0, o0, g0); check(1, o1, g1); check(2, o2, g2);
    for (int c = 0; c < NCYC; c++) begin
      rng = rng ^ (rng << 13);
      rng = rng ^ (rng >> 17);
      rng = rng ^ (rng << 5);
      req = rng[3:0] & {4{rng[20] | rng[21]}};
      ready = rng[4] | rng[5];
      split_resp = rng[6] & rng[7] & rng[8];
      split_release = rng[12:9] & rng[16:13] & {4{rng[17]}};
      model(0); model(1); model(2);
      @(negedge clk);
      check(0, o0, g0); check(1, o1, g1); check(2, o2, g2);
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule